// File: doc/BRIEF.md
# Synthesizer Divider and Three-State Phase Comparator

This block is the digital core of a frequency synthesizer loop. Two programmable 16-bit dividers, one fed by reference-clock events and one by oscillator feedback events, each emit a single-cycle pulse once per divide period. A three-state phase-frequency comparator watches the two divided pulse trains and decides whether the charge pump should source current, sink current, or stay in high impedance. All logic runs on one system clock. Each source is presented as a one-cycle tick input that marks one period of that source.

Control inputs set both divide ratios, pick which of two pump outputs carries the comparator's decisions, and enable or disable the pump. A 2-bit current code passes straight through to the analog pump. Each pump output is modelled as three digital controls: source, sink and high impedance.

Top module: `pll_synth_pd`

## Requirements
- R1: While reset is held, both pump outputs are high impedance (`pump_hiz` = 2'b11, `pump_up` = `pump_dn` = 0) and neither divided pulse is asserted.
- R2: With a ratio N of 2 or more, a divider asserts its pulse for exactly one clock once every N ticks. The pulse appears in the clock after the tick that completes the period. The first period after reset starts counting at the first tick.
- R3: A programmed ratio of 0 or 1 makes the divider behave exactly as ratio 2.
- R4: A new ratio written in the middle of a period does not shorten or lengthen that period. The divider samples the ratio input on the tick that ends each period and uses that value for the next period.
- R5: A reference pulse that finds no pending sink request sets the source request. While only the source request is set, the selected output drives source (`pump_up`). This is the case when the feedback is slower than, or lags, the reference.
- R6: A feedback pulse that finds no pending source request sets the sink request. While only the sink request is set, the selected output drives sink (`pump_dn`). This is the case when the feedback is faster than, or leads, the reference.
- R7: When both divided pulses occur in the same cycle, the outputs stay in high impedance.
- R8: One clock after both requests are set, both are cleared, except that a new pulse arriving in that cycle sets its own request again. No output ever shows source and sink together.
- R9: `cp_select` = 0 steers the comparator onto output index 0 and `cp_select` = 1 onto index 1. The unselected output stays high impedance.
- R10: With `cp_enable` = 0, both outputs are high impedance in the same cycle, whatever the comparator state.
- R11: `icp_code` equals `cp_current` in the same cycle. Codes 2'b00, 2'b01, 2'b10 and 2'b11 stand for 0.5, 1, 2 and 4 mA.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle event per reference period |
| fb_tick | input | 1 | One-cycle event per feedback oscillator period |
| ref_ratio | input | 16 | Reference divide ratio |
| fb_ratio | input | 16 | Feedback divide ratio |
| cp_enable | input | 1 | Pump enable; 0 forces both outputs to high impedance |
| cp_select | input | 1 | Selects which pump output is active |
| cp_current | input | 2 | Pump current code |
| pump_up | output | 2 | Per-output source control |
| pump_dn | output | 2 | Per-output sink control |
| pump_hiz | output | 2 | Per-output high-impedance control |
| icp_code | output | 2 | Current code passed to the pump |
| ref_pulse | output | 1 | Divided reference pulse |
| fb_pulse | output | 1 | Divided feedback pulse |

## Verification
Two events can fall in the same cycle: a divided reference pulse and a divided feedback pulse. A related case is a new pulse landing in the very cycle the comparator clears both requests. The bench provokes the first by running both dividers at equal ratios from a common tick, and the second by running slightly different ratios and interleaved tick rates. A behavioural model predicts the request state on every clock. Each cycle the outputs are judged against that model, and the bench also checks that no output ever shows source and sink together.

// File: rtl/pll_pd_pkg.sv
package pll_pd_pkg;

    localparam int DIV_W    = 16;
    localparam int NUM_OUTS = 2;
    localparam int ICP_W    = 2;

    // Request state held by the phase comparator
    typedef struct packed {
        logic up;
        logic dn;
    } pd_req_t;

    // Net drive direction requested of the pump
    typedef enum logic [1:0] {
        DIR_HIZ = 2'd0,
        DIR_SRC = 2'd1,
        DIR_SNK = 2'd2
    } pump_dir_e;

    // Ratios below two cannot divide; use the smallest legal ratio
    function automatic logic [DIV_W-1:0] legal_ratio(input logic [DIV_W-1:0] r);
        return (r < DIV_W'(2)) ? DIV_W'(2) : r;
    endfunction

    // Both requests set at once cancel to no drive
    function automatic pump_dir_e req_to_dir(input pd_req_t q);
        if (q.up && !q.dn) return DIR_SRC;
        if (q.dn && !q.up) return DIR_SNK;
        return DIR_HIZ;
    endfunction

endpackage

// File: rtl/pll_divider.sv
module pll_divider
    import pll_pd_pkg::*;
#(
    parameter int W = DIV_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic [W-1:0] ratio,
    output logic         pulse
);

    logic [W-1:0] count_q;
    logic [W-1:0] active_q;
    logic         terminal;

    assign terminal = (count_q == active_q - W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q  <= '0;
            active_q <= W'(legal_ratio(DIV_W'(ratio)));
            pulse    <= 1'b0;
        end else begin
            pulse <= 1'b0;
            if (tick) begin
                if (terminal) begin
                    count_q  <= '0;
                    active_q <= W'(legal_ratio(DIV_W'(ratio)));
                    pulse    <= 1'b1;
                end else begin
                    count_q <= count_q + W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/pll_phase_cmp.sv
module pll_phase_cmp
    import pll_pd_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    ref_p,
    input  logic    fb_p,
    output pd_req_t req
);

    always_ff @(posedge clk) begin
        if (rst) begin
            req <= '0;
        end else if (req.up && req.dn) begin
            // Clear both; a pulse landing now starts a new request
            req.up <= ref_p;
            req.dn <= fb_p;
        end else begin
            req.up <= req.up | ref_p;
            req.dn <= req.dn | fb_p;
        end
    end

endmodule

// File: rtl/pll_pump_steer.sv
module pll_pump_steer
    import pll_pd_pkg::*;
#(
    parameter int NOUT = NUM_OUTS,
    localparam int SELW = (NOUT > 1) ? $clog2(NOUT) : 1
) (
    input  logic            enable,
    input  logic [SELW-1:0] select,
    input  pd_req_t         req,
    output logic [NOUT-1:0] drv_up,
    output logic [NOUT-1:0] drv_dn,
    output logic [NOUT-1:0] drv_hiz
);

    pump_dir_e dir;
    assign dir = req_to_dir(req);

    for (genvar i = 0; i < NOUT; i++) begin : g_out
        logic active;
        assign active     = enable && (select == SELW'(i));
        assign drv_up[i]  = active && (dir == DIR_SRC);
        assign drv_dn[i]  = active && (dir == DIR_SNK);
        assign drv_hiz[i] = !(drv_up[i] || drv_dn[i]);
    end

endmodule

// File: rtl/pll_synth_pd.sv
module pll_synth_pd
    import pll_pd_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                ref_tick,
    input  logic                fb_tick,
    input  logic [DIV_W-1:0]    ref_ratio,
    input  logic [DIV_W-1:0]    fb_ratio,
    input  logic                cp_enable,
    input  logic                cp_select,
    input  logic [ICP_W-1:0]    cp_current,
    output logic [NUM_OUTS-1:0] pump_up,
    output logic [NUM_OUTS-1:0] pump_dn,
    output logic [NUM_OUTS-1:0] pump_hiz,
    output logic [ICP_W-1:0]    icp_code,
    output logic                ref_pulse,
    output logic                fb_pulse
);

    pd_req_t req;
    logic    pfd_up;
    logic    pfd_dn;

    pll_divider #(.W(DIV_W)) u_ref_div (
        .clk   (clk),
        .rst   (rst),
        .tick  (ref_tick),
        .ratio (ref_ratio),
        .pulse (ref_pulse)
    );

    pll_divider #(.W(DIV_W)) u_fb_div (
        .clk   (clk),
        .rst   (rst),
        .tick  (fb_tick),
        .ratio (fb_ratio),
        .pulse (fb_pulse)
    );

    pll_phase_cmp u_cmp (
        .clk   (clk),
        .rst   (rst),
        .ref_p (ref_pulse),
        .fb_p  (fb_pulse),
        .req   (req)
    );

    assign pfd_up = req.up;
    assign pfd_dn = req.dn;

    pll_pump_steer #(.NOUT(NUM_OUTS)) u_steer (
        .enable  (cp_enable),
        .select  (cp_select),
        .req     (req),
        .drv_up  (pump_up),
        .drv_dn  (pump_dn),
        .drv_hiz (pump_hiz)
    );

    assign icp_code = cp_current;

endmodule

// File: rtl/pll_synth_pd_chk.sv
module pll_synth_pd_chk (
    input logic       clk,
    input logic       rst,
    input logic       ref_pulse,
    input logic       fb_pulse,
    input logic       pfd_up,
    input logic       pfd_dn,
    input logic       cp_enable,
    input logic       cp_select,
    input logic [1:0] pump_up,
    input logic [1:0] pump_dn,
    input logic [1:0] pump_hiz
);

    // R2: a divided pulse lasts one clock
    p_ref_single_r2: assert property (@(posedge clk) disable iff (rst)
        ref_pulse |=> !ref_pulse);
    p_fb_single_r2: assert property (@(posedge clk) disable iff (rst)
        fb_pulse |=> !fb_pulse);

    // R5: a reference pulse with no pending sink request sets source
    p_src_set_r5: assert property (@(posedge clk) disable iff (rst)
        (ref_pulse && !pfd_dn) |=> pfd_up);

    // R6: a feedback pulse with no pending source request sets sink
    p_snk_set_r6: assert property (@(posedge clk) disable iff (rst)
        (fb_pulse && !pfd_up) |=> pfd_dn);

    // R8: both requests clear one clock later when no new pulse arrives
    p_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (pfd_up && pfd_dn && !ref_pulse && !fb_pulse) |=> (!pfd_up && !pfd_dn));

    // R8: no output shows source and sink together
    p_excl_r8: assert property (@(posedge clk) disable iff (rst)
        (pump_up & pump_dn) == 2'b00);

    // R9: the unselected output stays high impedance
    p_unsel_r9: assert property (@(posedge clk) disable iff (rst)
        (cp_enable && !cp_select) |-> (pump_hiz[1] && !pump_up[1] && !pump_dn[1]));

    // R10: disable forces high impedance on both outputs
    p_disable_r10: assert property (@(posedge clk) disable iff (rst)
        !cp_enable |-> (pump_hiz == 2'b11 && pump_up == 2'b00 && pump_dn == 2'b00));

endmodule

bind pll_synth_pd pll_synth_pd_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .ref_pulse (ref_pulse),
    .fb_pulse  (fb_pulse),
    .pfd_up    (pfd_up),
    .pfd_dn    (pfd_dn),
    .cp_enable (cp_enable),
    .cp_select (cp_select),
    .pump_up   (pump_up),
    .pump_dn   (pump_dn),
    .pump_hiz  (pump_hiz)
);

// File: tb/tb_pll_synth_pd.sv
`timescale 1ns/100ps
module tb_pll_synth_pd;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ref_tick = 1'b0;
    logic        fb_tick = 1'b0;
    logic [15:0] ref_ratio = 16'd4;
    logic [15:0] fb_ratio = 16'd4;
    logic        cp_enable = 1'b1;
    logic        cp_select = 1'b0;
    logic [1:0]  cp_current = 2'b00;
    logic [1:0]  pump_up, pump_dn, pump_hiz, icp_code;
    logic        ref_pulse, fb_pulse;

    always #2.5 clk = ~clk;

    pll_synth_pd dut (
        .clk(clk), .rst(rst), .ref_tick(ref_tick), .fb_tick(fb_tick),
        .ref_ratio(ref_ratio), .fb_ratio(fb_ratio), .cp_enable(cp_enable),
        .cp_select(cp_select), .cp_current(cp_current), .pump_up(pump_up),
        .pump_dn(pump_dn), .pump_hiz(pump_hiz), .icp_code(icp_code),
        .ref_pulse(ref_pulse), .fb_pulse(fb_pulse)
    );

    int    errors = 0;
    int    checks = 0;
    string cur_req = "R1";
    bit    done = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    int m_rcnt, m_ract, m_fcnt, m_fact;
    bit m_rp, m_fp, m_up, m_dn;
    int seen_up0, seen_dn0, seen_up1, seen_dn1, seen_ref;

    function automatic int clampr(input int r);
        return (r < 2) ? 2 : r;
    endfunction

    always @(posedge clk) begin
        bit nu, nd, nrp, nfp;
        bit eu, ed;
        int exp_up, exp_dn, exp_hiz;
        if (rst) begin
            m_rcnt = 0; m_ract = clampr(int'(ref_ratio));
            m_fcnt = 0; m_fact = clampr(int'(fb_ratio));
            m_rp = 0; m_fp = 0; m_up = 0; m_dn = 0;
        end else begin
            if (m_up && m_dn) begin nu = m_rp; nd = m_fp; end
            else begin nu = m_up | m_rp; nd = m_dn | m_fp; end
            nrp = 0; nfp = 0;
            if (ref_tick) begin
                if (m_rcnt == m_ract - 1) begin
                    nrp = 1; m_rcnt = 0; m_ract = clampr(int'(ref_ratio));
                end else m_rcnt++;
            end
            if (fb_tick) begin
                if (m_fcnt == m_fact - 1) begin
                    nfp = 1; m_fcnt = 0; m_fact = clampr(int'(fb_ratio));
                end else m_fcnt++;
            end
            m_up = nu; m_dn = nd; m_rp = nrp; m_fp = nfp;
        end
        #1;
        if (!done) begin
            eu = m_up && !m_dn;
            ed = m_dn && !m_up;
            exp_up = 0; exp_dn = 0;
            if (cp_enable) begin
                exp_up = eu ? (cp_select ? 2 : 1) : 0;
                exp_dn = ed ? (cp_select ? 2 : 1) : 0;
            end
            exp_hiz = 3 & ~(exp_up | exp_dn);
            chk(cur_req, "ref_pulse", int'(ref_pulse), int'(m_rp));
            chk(cur_req, "fb_pulse", int'(fb_pulse), int'(m_fp));
            chk(cur_req, "pump_up", int'(pump_up), exp_up);
            chk(cur_req, "pump_dn", int'(pump_dn), exp_dn);
            chk(cur_req, "pump_hiz", int'(pump_hiz), exp_hiz);
            chk("R11", "icp_code", int'(icp_code), int'(cp_current));
            chk("R8", "source and sink together", int'(pump_up & pump_dn), 0);
            if (pump_up[0]) seen_up0++;
            if (pump_dn[0]) seen_dn0++;
            if (pump_up[1]) seen_up1++;
            if (pump_dn[1]) seen_dn1++;
            if (ref_pulse) seen_ref++;
        end
    end

    task automatic clear_seen();
        seen_up0 = 0; seen_dn0 = 0; seen_up1 = 0; seen_dn1 = 0; seen_ref = 0;
    endtask

    // Drive ticks: reference every re cycles, feedback every fe cycles
    task automatic run(input int n, input int re, input int fe);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ref_tick = (i % re) == 0;
            fb_tick  = (i % fe) == 0;
        end
        @(negedge clk);
        ref_tick = 0;
        fb_tick  = 0;
    endtask

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 150000 && !done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<150000 cycles", wd);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        cur_req = "R1";
        repeat (3) @(negedge clk);
        chk("R1", "pump_hiz in reset", int'(pump_hiz), 3);
        chk("R1", "ref_pulse in reset", int'(ref_pulse), 0);
        chk("R1", "pump_up in reset", int'(pump_up), 0);
        rst = 0;

        // Coincident pulses: equal ratios, common tick
        cur_req = "R7";
        clear_seen();
        run(40, 1, 1);
        chk("R7", "source cycles with coincident pulses", seen_up0, 0);
        chk("R7", "sink cycles with coincident pulses", seen_dn0, 0);

        // Feedback slower than reference
        cur_req = "R5";
        fb_ratio = 16'd5;
        clear_seen();
        run(60, 1, 1);
        chk("R5", "source seen when feedback slow", int'(seen_up0 > 0), 1);

        // Feedback faster than reference
        cur_req = "R6";
        ref_ratio = 16'd5;
        fb_ratio = 16'd4;
        run(10, 1, 1);
        clear_seen();
        run(60, 1, 1);
        chk("R6", "sink seen when feedback fast", int'(seen_dn0 > 0), 1);

        // Output select
        cur_req = "R9";
        cp_select = 1;
        clear_seen();
        run(40, 1, 1);
        chk("R9", "output 0 idle when output 1 selected", seen_up0 + seen_dn0, 0);
        chk("R9", "output 1 active", int'(seen_dn1 > 0), 1);

        // Disable
        cur_req = "R10";
        cp_enable = 0;
        clear_seen();
        run(40, 1, 1);
        chk("R10", "drive cycles while disabled", seen_up0 + seen_dn0 + seen_up1 + seen_dn1, 0);
        cp_enable = 1;
        cp_select = 0;

        // Current code passthrough
        cur_req = "R11";
        for (int c = 0; c < 4; c++) begin
            cp_current = 2'(c);
            run(6, 1, 2);
        end

        // Ratios 0 and 1 act as 2
        cur_req = "R3";
        ref_ratio = 16'd0;
        fb_ratio = 16'd2;
        run(8, 1, 1);
        clear_seen();
        run(20, 1, 1);
        chk("R3", "ref pulses with ratio 0", seen_ref, 10);
        ref_ratio = 16'd1;
        run(8, 1, 1);
        clear_seen();
        run(20, 1, 1);
        chk("R3", "ref pulses with ratio 1", seen_ref, 10);

        // Mid-period ratio change
        cur_req = "R4";
        ref_ratio = 16'd8;
        fb_ratio = 16'd8;
        run(12, 1, 1);
        ref_ratio = 16'd3;
        run(30, 1, 1);
        fb_ratio = 16'd3;
        ref_ratio = 16'd7;
        run(30, 1, 1);

        // Irregular ticks, equal divided frequency
        cur_req = "R2";
        ref_ratio = 16'd2;
        fb_ratio = 16'd3;
        run(60, 3, 2);
        ref_ratio = 16'd9;
        fb_ratio = 16'd6;
        run(80, 2, 3);

        // Reset mid-run
        cur_req = "R1";
        @(negedge clk);
        rst = 1;
        repeat (2) @(negedge clk);
        chk("R1", "pump_hiz after re-reset", int'(pump_hiz), 3);
        rst = 0;
        run(10, 1, 1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule